// File: doc/BRIEF.md
# Bank-Switching Memory Management Unit

This block widens the addresses of a small 8-bit controller so that it can reach a 128 KB static RAM. Program fetches carry a 12-bit program counter and external data accesses carry an 8-bit index register. Neither is enough on its own. The block supplies the upper nine RAM address lines, A16 down to A8. Program space and data space are told apart by A16, and a 4 KB program bank or a 256-byte data page is picked by bank registers that software loads.

Software loads the bank registers through the controller's nibble-wide port-expander protocol. The falling edge of the expander strobe carries an opcode and a port number on the low nibble of port 2, and the rising edge carries a data nibble. Two load opcodes are recognised, a plain load and an OR-form load. The choice of opcode also sets a mode flag. A plain load restores separate program and data spaces. An OR-form load pulls A16 low for every access, so the controller can write into its own program memory.

A new program bank does not take effect at once. It waits until the program counter leaves its sequential path, so the jump, call or return that follows the bank write is still fetched from the old bank. A strap selects a small-map mode, in which the low data page follows port 2 on every address-latch cycle and the expander strobe no longer changes the upper page or the program bank. The block also decodes one 256-byte page as a memory-mapped I/O window, and it drives the RAM output enable from the two read strobes.

Top module: `bank_mmu`

## Requirements
- R1: After reset, with no strobe active, addr_hi is 0x100, io_sel is 0 and ram_oe_n is 1.
- R2: ram_oe_n is 0 in every cycle in which psen_n or rd_n is 0, and 1 when both are 1.
- R3: A falling edge of prog captures the opcode from p2_lo[3:2] and the port from p2_lo[1:0]. The following rising edge of prog loads p2_lo[3:0] into the register that the port selects: port 0 is the low data page, port 1 the high data page, port 2 the program bank and port 3 the extension nibble. Only opcode 01 (plain load) and opcode 10 (OR-form load) load a register. Opcodes 00 and 11 change nothing.
- R4: A plain load sets the space-split flag to 1 and an OR-form load clears it to 0. While the flag is 0, A16 (addr_hi[8]) is 0 for data accesses too.
- R5: While psen_n is 0, addr_hi equals {0, program bank, PC[11:8]}. PC[11:8] is the p2_lo value captured at the falling edge of ale.
- R6: While psen_n is 1, addr_hi equals {split flag, high data page, low data page}.
- R7: A program bank written through port 2 is held pending. It takes effect on the first fetch whose address, captured at the ale falling edge as {p2_lo, bus_ad}, differs from the previous fetch address plus one (modulo 4096), and it is already visible during that fetch. Sequential fetches keep using the old bank.
- R8: With strap_small at 1, the low data page is loaded from p2_lo at every falling edge of ale, and loads to port 1 and port 2 are ignored.
- R9: io_sel is 1 only when psen_n is 1, strap_io is 1, bit 3 of the extension nibble is 1 and addr_hi equals 0x1FD. Otherwise io_sel is 0.
- R10: Reset clears all bank registers and bit 3 of the extension nibble, sets the split flag, and takes 0xFFF as the previous fetch address, so a first fetch at 0x000 counts as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 8 | Multiplexed low address and data bus |
| p2_lo | input | 4 | Low nibble of port 2 (PC[11:8], expander opcode, port and data) |
| ale | input | 1 | Address latch enable, high while the address is on the bus |
| psen_n | input | 1 | Program fetch strobe, active low |
| rd_n | input | 1 | External data read strobe, active low |
| prog | input | 1 | Expander strobe, idle high |
| strap_small | input | 1 | Small-map strap |
| strap_io | input | 1 | Strap allowing the I/O window |
| addr_hi | output | 9 | RAM address lines A16..A8 |
| io_sel | output | 1 | High while the I/O window is addressed |
| ram_oe_n | output | 1 | RAM output enable, active low |

## Verification
A bank write and a change of the program counter's path can meet in one stream of fetches. The pending bank has to stay hidden during the sequential fetch that follows the write, and it has to appear during the first non-sequential fetch. The bench provokes this by writing the bank and then fetching one sequential address and one distant address. It judges the output against the fetch address the reference model last recorded. In small-map mode an address-latch cycle and a page write both target the low data page, so the bench runs a data access with a fresh port-2 page and confirms that the page follows port 2 while writes to the other ports are dropped.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;

  localparam int NIB_W = 4;
  localparam int RI_W  = 8;
  localparam int PC_W  = 12;
  localparam int PCH_W = PC_W - RI_W;
  localparam int HI_W  = 1 + NIB_W + PCH_W;
  localparam int OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    XOP_READ = 2'b00,
    XOP_LOAD = 2'b01,
    XOP_OR   = 2'b10,
    XOP_AND  = 2'b11
  } xop_e;

  typedef enum logic [OP_W-1:0] {
    XP_DLO   = 2'd0,
    XP_DHI   = 2'd1,
    XP_PBANK = 2'd2,
    XP_EXT   = 2'd3
  } xport_e;

endpackage

// File: rtl/mmu_xp_regs.sv
module mmu_xp_regs
  import bank_mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog,
  input  logic [NIB_W-1:0] p2,
  input  logic             small_map,
  input  logic             ale_fall,
  output logic [NIB_W-1:0] dlo,
  output logic [NIB_W-1:0] dhi,
  output logic             da16,
  output logic             io_open,
  output logic             pb_wr,
  output logic [NIB_W-1:0] pb_val
);

  logic             prog_q;
  xop_e             op_q, op_n;
  xport_e           port_q, port_n;
  logic [NIB_W-1:0] dlo_n, dhi_n;
  logic             da16_n, io_open_n;
  logic             prog_fall, prog_rise, do_load;

  assign prog_fall = prog_q & ~prog;
  assign prog_rise = ~prog_q & prog;
  assign do_load   = prog_rise & ((op_q == XOP_LOAD) | (op_q == XOP_OR));
  assign pb_wr     = do_load & (port_q == XP_PBANK) & ~small_map;
  assign pb_val    = p2;

  always_comb begin
    op_n      = op_q;
    port_n    = port_q;
    dlo_n     = dlo;
    dhi_n     = dhi;
    da16_n    = da16;
    io_open_n = io_open;
    if (prog_fall) begin
      op_n   = xop_e'(p2[NIB_W-1 -: OP_W]);
      port_n = xport_e'(p2[OP_W-1:0]);
    end
    if (do_load) begin
      da16_n = (op_q == XOP_LOAD);
      if (port_q == XP_DLO) dlo_n = p2;
      if ((port_q == XP_DHI) && !small_map) dhi_n = p2;
      if (port_q == XP_EXT) io_open_n = p2[NIB_W-1];
    end
    if (small_map && ale_fall) dlo_n = p2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      op_q    <= XOP_READ;
      port_q  <= XP_DLO;
      dlo     <= '0;
      dhi     <= '0;
      da16    <= 1'b1;
      io_open <= 1'b0;
    end else begin
      prog_q  <= prog;
      op_q    <= op_n;
      port_q  <= port_n;
      dlo     <= dlo_n;
      dhi     <= dhi_n;
      da16    <= da16_n;
      io_open <= io_open_n;
    end
  end

endmodule

// File: rtl/mmu_fetch_track.sv
module mmu_fetch_track
  import bank_mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic             psen_n,
  input  logic [NIB_W-1:0] p2,
  input  logic [RI_W-1:0]  bus,
  input  logic             pb_wr,
  input  logic [NIB_W-1:0] pb_val,
  output logic             ale_fall,
  output logic [PC_W-1:0]  pc_lat,
  output logic [NIB_W-1:0] pbank_eff
);

  logic             ale_q, psen_q, jump_q, pend;
  logic [PC_W-1:0]  prev_pc, pc_lat_n, prev_pc_n, pc_seq, pc_in;
  logic             jump_n, pend_n, psen_rise;
  logic [NIB_W-1:0] pbank, pbank_n, pend_val, pend_val_n;

  assign ale_fall  = ale_q & ~ale;
  assign psen_rise = ~psen_q & psen_n;
  assign pc_in     = {p2, bus};
  assign pc_seq    = prev_pc + PC_W'(1);
  assign pbank_eff = (pend && jump_q) ? pend_val : pbank;

  always_comb begin
    pc_lat_n   = pc_lat;
    jump_n     = jump_q;
    prev_pc_n  = prev_pc;
    pbank_n    = pbank;
    pend_n     = pend;
    pend_val_n = pend_val;
    if (ale_fall) begin
      pc_lat_n = pc_in;
      jump_n   = (pc_in != pc_seq);
    end
    if (psen_rise) prev_pc_n = pc_lat;
    if (pb_wr) begin
      pend_n     = 1'b1;
      pend_val_n = pb_val;
    end else if (psen_rise && pend && jump_q) begin
      pbank_n = pend_val;
      pend_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      psen_q   <= 1'b1;
      pc_lat   <= '0;
      jump_q   <= 1'b0;
      prev_pc  <= '1;
      pbank    <= '0;
      pend     <= 1'b0;
      pend_val <= '0;
    end else begin
      ale_q    <= ale;
      psen_q   <= psen_n;
      pc_lat   <= pc_lat_n;
      jump_q   <= jump_n;
      prev_pc  <= prev_pc_n;
      pbank    <= pbank_n;
      pend     <= pend_n;
      pend_val <= pend_val_n;
    end
  end

endmodule

// File: rtl/mmu_addr_map.sv
module mmu_addr_map
  import bank_mmu_pkg::*;
#(
  parameter logic [HI_W-1:0] IO_PAGE = 9'h1FD
) (
  input  logic             psen_n,
  input  logic             strap_io,
  input  logic             io_open,
  input  logic             da16,
  input  logic [NIB_W-1:0] dlo,
  input  logic [NIB_W-1:0] dhi,
  input  logic [NIB_W-1:0] pbank,
  input  logic [PCH_W-1:0] pc_hi,
  output logic [HI_W-1:0]  addr_hi,
  output logic             io_sel
);

  logic [HI_W-1:0] fetch_addr, data_addr;

  assign fetch_addr = {1'b0, pbank, pc_hi};
  assign data_addr  = {da16, dhi, dlo};

  always_comb begin
    addr_hi = psen_n ? data_addr : fetch_addr;
    io_sel  = psen_n && strap_io && io_open && (data_addr == IO_PAGE);
  end

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import bank_mmu_pkg::*;
#(
  parameter logic [HI_W-1:0] IO_PAGE = 9'h1FD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RI_W-1:0]  bus_ad,
  input  logic [NIB_W-1:0] p2_lo,
  input  logic             ale,
  input  logic             psen_n,
  input  logic             rd_n,
  input  logic             prog,
  input  logic             strap_small,
  input  logic             strap_io,
  output logic [HI_W-1:0]  addr_hi,
  output logic             io_sel,
  output logic             ram_oe_n
);

  logic [NIB_W-1:0] dlo, dhi, pb_val, pbank_eff;
  logic             da16, io_open, pb_wr, ale_fall;
  logic [PC_W-1:0]  pc_lat;

  mmu_xp_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog      (prog),
    .p2        (p2_lo),
    .small_map (strap_small),
    .ale_fall  (ale_fall),
    .dlo       (dlo),
    .dhi       (dhi),
    .da16      (da16),
    .io_open   (io_open),
    .pb_wr     (pb_wr),
    .pb_val    (pb_val)
  );

  mmu_fetch_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .psen_n    (psen_n),
    .p2        (p2_lo),
    .bus       (bus_ad),
    .pb_wr     (pb_wr),
    .pb_val    (pb_val),
    .ale_fall  (ale_fall),
    .pc_lat    (pc_lat),
    .pbank_eff (pbank_eff)
  );

  mmu_addr_map #(.IO_PAGE(IO_PAGE)) u_map (
    .psen_n   (psen_n),
    .strap_io (strap_io),
    .io_open  (io_open),
    .da16     (da16),
    .dlo      (dlo),
    .dhi      (dhi),
    .pbank    (pbank_eff),
    .pc_hi    (pc_lat[PC_W-1 -: PCH_W]),
    .addr_hi  (addr_hi),
    .io_sel   (io_sel)
  );

  assign ram_oe_n = psen_n & rd_n;

endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk
  import bank_mmu_pkg::*;
#(
  parameter logic [HI_W-1:0] IO_PAGE = 9'h1FD
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             psen_n,
  input logic             rd_n,
  input logic             strap_small,
  input logic [NIB_W-1:0] p2_lo,
  input logic [HI_W-1:0]  addr_hi,
  input logic             io_sel,
  input logic             ram_oe_n
);

  p_oe_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ram_oe_n);

  p_oe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ram_oe_n);

  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n) |-> ram_oe_n);

  p_fetch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !addr_hi[HI_W-1]);

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n && !$past(psen_n)) |-> $stable(addr_hi));

  p_small_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_small && $fell(ale)) |=> (!psen_n || addr_hi[NIB_W-1:0] == $past(p2_lo)));

  p_io_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !io_sel);

  p_io_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> addr_hi == IO_PAGE);

endmodule

bind bank_mmu bank_mmu_chk #(.IO_PAGE(IO_PAGE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ale         (ale),
  .psen_n      (psen_n),
  .rd_n        (rd_n),
  .strap_small (strap_small),
  .p2_lo       (p2_lo),
  .addr_hi     (addr_hi),
  .io_sel      (io_sel),
  .ram_oe_n    (ram_oe_n)
);

// File: tb/bank_mmu_bench.sv
`timescale 1ns/1ps
module bank_mmu_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_ad;
  logic [3:0] p2_lo;
  logic       ale, psen_n, rd_n, prog, strap_small, strap_io;
  logic [8:0] addr_hi;
  logic       io_sel, ram_oe_n;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  bank_mmu u_bank_mmu (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .p2_lo(p2_lo), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .prog(prog), .strap_small(strap_small),
    .strap_io(strap_io), .addr_hi(addr_hi), .io_sel(io_sel), .ram_oe_n(ram_oe_n)
  );

  // Behavioural reference model, updated on each rising edge
  bit m_prog_q, m_ale_q, m_psen_q, m_jump, m_pend, m_da16, m_io;
  int m_op, m_port, m_lat, m_prev, m_dlo, m_dhi, m_pb, m_pval;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prog_q = 1; m_ale_q = 0; m_psen_q = 1; m_jump = 0; m_pend = 0;
      m_da16 = 1; m_io = 0; m_op = 0; m_port = 0; m_lat = 0; m_prev = 4095;
      m_dlo = 0; m_dhi = 0; m_pb = 0; m_pval = 0;
    end else begin
      if (prog && !m_prog_q && (m_op == 1 || m_op == 2)) begin
        m_da16 = (m_op == 1);
        case (m_port)
          0: m_dlo = int'(p2_lo);
          1: if (!strap_small) m_dhi = int'(p2_lo);
          2: if (!strap_small) begin m_pend = 1; m_pval = int'(p2_lo); end
          default: m_io = p2_lo[3];
        endcase
      end
      if (!prog && m_prog_q) begin
        m_op = int'(p2_lo) / 4;
        m_port = int'(p2_lo) % 4;
      end
      if (!ale && m_ale_q) begin
        m_lat  = int'(p2_lo) * 256 + int'(bus_ad);
        m_jump = (m_lat != (m_prev + 1) % 4096);
        if (strap_small) m_dlo = int'(p2_lo);
      end
      if (psen_n && !m_psen_q) begin
        m_prev = m_lat;
        if (m_pend && m_jump) begin m_pb = m_pval; m_pend = 0; end
      end
      m_prog_q = prog; m_ale_q = ale; m_psen_q = psen_n;
    end
  end

  function automatic logic [8:0] model_hi();
    int pe;
    pe = (m_pend && m_jump) ? m_pval : m_pb;
    if (!psen_n) return {1'b0, 4'(pe), 4'(m_lat / 256)};
    return {m_da16, 4'(m_dhi), 4'(m_dlo)};
  endfunction

  // Per-clock comparison against the model
  always @(posedge clk) begin
    logic [8:0] eh;
    logic       ei, eo;
    #1;
    if (rst_n && !done) begin
      eh = model_hi();
      ei = psen_n && strap_io && m_io && (eh == 9'h1FD);
      eo = psen_n && rd_n;
      n_chk++;
      if (addr_hi !== eh || io_sel !== ei || ram_oe_n !== eo) begin
        n_fail++;
        $display("FAIL %s per-clock: addr_hi=%h io_sel=%b ram_oe_n=%b, expected %h %b %b",
                 cur_req, addr_hi, io_sel, ram_oe_n, eh, ei, eo);
      end
    end
  end

  task automatic chk(input string tag, input logic [8:0] ea, input logic ei, input logic eo);
    @(posedge clk); #1;
    n_chk++;
    if (addr_hi !== ea || io_sel !== ei || ram_oe_n !== eo) begin
      n_fail++;
      $display("FAIL %s: addr_hi=%h io_sel=%b ram_oe_n=%b, expected %h %b %b",
               tag, addr_hi, io_sel, ram_oe_n, ea, ei, eo);
    end
  endtask

  task automatic idle_step();
    @(negedge clk);
    ale = 0; psen_n = 1; rd_n = 1; prog = 1;
  endtask

  task automatic xop(input int op, input int port, input int nib);
    @(negedge clk); p2_lo = 4'(op * 4 + port);
    @(negedge clk); prog = 0;
    @(negedge clk); p2_lo = 4'(nib);
    @(negedge clk); prog = 1;
    @(negedge clk);
  endtask

  task automatic fetch(input int pc, input bit do_chk, input logic [8:0] ea, input string tag);
    @(negedge clk); ale = 1; p2_lo = 4'(pc / 256); bus_ad = 8'(pc);
    @(negedge clk); ale = 0;
    @(negedge clk); psen_n = 0;
    if (do_chk) chk(tag, ea, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk); psen_n = 1;
    @(negedge clk);
  endtask

  task automatic dacc(input int page, input int ri, input bit do_chk, input logic [8:0] ea,
                      input logic ei, input string tag);
    @(negedge clk); ale = 1; p2_lo = 4'(page); bus_ad = 8'(ri);
    @(negedge clk); ale = 0;
    @(negedge clk); rd_n = 0;
    if (do_chk) chk(tag, ea, ei, 1'b0);
    @(negedge clk);
    @(negedge clk); rd_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    int pc;
    rst_n = 0; bus_ad = 0; p2_lo = 0; ale = 0; psen_n = 1; rd_n = 1; prog = 1;
    strap_small = 0; strap_io = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    chk("R1 reset idle", 9'h100, 1'b0, 1'b1);
    chk("R10 reset split flag and closed window", 9'h100, 1'b0, 1'b1);

    cur_req = "R2";
    dacc(0, 8'h40, 1, 9'h100, 1'b0, "R2 read enables ram");

    cur_req = "R3";
    xop(1, 0, 3);
    xop(1, 1, 5);
    chk("R3 low and high page load", 9'h153, 1'b0, 1'b1);
    xop(0, 1, 10);
    chk("R3 opcode 00 ignored", 9'h153, 1'b0, 1'b1);
    xop(3, 0, 10);
    chk("R3 opcode 11 ignored", 9'h153, 1'b0, 1'b1);

    cur_req = "R4";
    xop(2, 0, 7);
    chk("R4 OR-form load forces A16 low", 9'h057, 1'b0, 1'b1);
    xop(1, 0, 3);
    chk("R4 plain load restores A16", 9'h153, 1'b0, 1'b1);

    cur_req = "R5";
    fetch(12'h000, 1, 9'h000, "R5 fetch 000 with R10 sequential start");
    fetch(12'h001, 1, 9'h000, "R5 fetch 001");
    fetch(12'h2AB, 1, 9'h002, "R5 fetch 2AB");

    cur_req = "R7";
    xop(1, 2, 9);
    chk("R7 pending bank hidden from data form", 9'h153, 1'b0, 1'b1);
    fetch(12'h2AC, 1, 9'h002, "R7 sequential fetch keeps old bank");
    fetch(12'h3F0, 1, 9'h093, "R7 jump applies new bank");
    fetch(12'h3F1, 1, 9'h093, "R7 bank retained");
    xop(1, 2, 4);
    fetch(12'h3F2, 1, 9'h093, "R7 second write still pending");
    fetch(12'h100, 1, 9'h041, "R7 second jump applies bank 4");
    xop(1, 2, 9);
    fetch(12'h3F0, 1, 9'h093, "R7 return to bank 9");

    cur_req = "R6";
    xop(1, 1, 15);
    xop(1, 0, 13);
    chk("R6 data form page 1FD window closed", 9'h1FD, 1'b0, 1'b1);

    cur_req = "R9";
    @(negedge clk); strap_io = 1;
    chk("R9 strap alone does not open", 9'h1FD, 1'b0, 1'b1);
    xop(1, 3, 8);
    chk("R9 window open", 9'h1FD, 1'b1, 1'b1);
    dacc(13, 8'h22, 1, 9'h1FD, 1'b1, "R9 window during read");
    fetch(12'h3F1, 1, 9'h093, "R9 no window on fetch");
    @(negedge clk); strap_io = 0;
    chk("R9 strap low closes window", 9'h1FD, 1'b0, 1'b1);
    @(negedge clk); strap_io = 1;
    xop(2, 3, 8);
    chk("R9 A16 low leaves window", 9'h0FD, 1'b0, 1'b1);
    xop(1, 3, 0);
    chk("R9 extension bit cleared closes window", 9'h1FD, 1'b0, 1'b1);

    cur_req = "R8";
    @(negedge clk); strap_small = 1;
    dacc(6, 8'h12, 1, 9'h1F6, 1'b0, "R8 low page follows port 2");
    xop(1, 1, 2);
    chk("R8 high page load ignored", 9'h1F6, 1'b0, 1'b1);
    xop(1, 2, 4);
    fetch(12'h500, 1, 9'h095, "R8 program bank load ignored");
    chk("R8 page from fetch address cycle", 9'h1F5, 1'b0, 1'b1);
    @(negedge clk); strap_small = 0;

    cur_req = "R6";
    pc = 0;
    for (int i = 0; i < 300; i++) begin
      int k;
      k = int'($urandom_range(0, 4));
      case (k)
        0: xop(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 15)));
        1: begin pc = int'($urandom_range(0, 4095)); fetch(pc, 0, 9'h000, "R7"); end
        2: begin pc = (pc + 1) % 4096; fetch(pc, 0, 9'h000, "R7"); end
        3: dacc(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), 0, 9'h000, 1'b0, "R6");
        default: begin
          @(negedge clk);
          strap_small = 1'($urandom_range(0, 1));
          strap_io = 1'($urandom_range(0, 1));
        end
      endcase
    end
    idle_step();
    idle_step();
    finish_run();
  end

endmodule